// File: doc/BRIEF.md
# DRAM Mode Register Programming Decoder

This block sits on the memory side of a double data rate DRAM and watches the registered command pins on every rising clock edge. A command is seen only when the clock enable input was high on the previous edge and on this one. When chip select, row strobe, column strobe and write enable are all low, the command is a register write. Bank address bit 0 then picks the target. When it is low the write goes to the main mode register, which holds burst length, burst order, read latency and the DLL reset request. When it is high the write goes to the extended mode register, which holds DLL enable and output drive strength.

A write takes effect only if all banks are idle, the minimum spacing after the previous accepted write has passed, and every field holds a supported code with all reserved bits at zero. A write that fails any of these rules is rejected and leaves the stored fields as they were. It also sets an error flag that stays set until reset. The block reports the configuration as not yet valid until the extended register has been written and a main register write has followed it.

Top module: `mode_reg_decoder`

## Requirements
- R1: After reset, burst_len, burst_interleave, read_lat_x2, dll_on, drive_weak, dll_reset_pulse, cfg_valid and err are all 0.
- R2: An accepted main write (ba[0]=0) sets burst_len from addr[2:0]: code 001 gives 2, 010 gives 4 and 011 gives 8. Codes 000 and 100 to 111 are rejected.
- R3: An accepted main write sets burst_interleave to addr[3] (0 = sequential, 1 = interleaved).
- R4: An accepted main write sets read_lat_x2, the read latency in half clocks, from addr[6:4]: code 011 gives 6 and code 110 gives 5. Every other code is rejected.
- R5: An accepted extended write (ba[0]=1) sets dll_on to the inverse of addr[0] and drive_weak to addr[1]. addr[6] is ignored. A nonzero value in ba[1], addr[5:2] or addr[12:7] rejects the write.
- R6: A main write with addr[8]=1 that is otherwise legal is accepted and raises dll_reset_pulse for exactly one cycle after its edge. A main write with addr[7], ba[1] or any of addr[12:9] set is rejected.
- R7: A register write while banks_idle is 0 is rejected.
- R8: Any command other than NOP (cs_n low and not all of ras_n, cas_n, we_n high) on the TMRD-1 edges after an accepted write is rejected. A write TMRD edges later is accepted. TMRD defaults to 2.
- R9: cfg_valid goes to 1 on an accepted main write that comes after an accepted extended write, and then stays at 1. A main write with no extended write before it leaves cfg_valid at 0.
- R10: A rejected write sets err, leaves every stored field unchanged, and err stays at 1 until reset.
- R11: A command is ignored, with no error and no change, if cke was low on this edge or on the previous edge, or if cs_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; inputs are sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address; bit 0 selects the register |
| addr | input | AW | Address bits carrying the register value |
| banks_idle | input | 1 | High when all banks are precharged |
| burst_len | output | 4 | Burst length in beats (0 until programmed) |
| burst_interleave | output | 1 | 1 = interleaved burst order |
| read_lat_x2 | output | 3 | Read latency in half clocks (0 until programmed) |
| dll_on | output | 1 | DLL enabled |
| drive_weak | output | 1 | Reduced output drive selected |
| dll_reset_pulse | output | 1 | One-cycle DLL reset request |
| cfg_valid | output | 1 | Extended then main register written |
| err | output | 1 | Sticky flag for a rejected command |

## Verification
The embedded assertions check four properties on every cycle. Once set, err and cfg_valid never clear without a reset. A write seen while a bank is busy changes no stored field. A DLL reset pulse always follows a main write with addr[8] set. The bench scenarios are needed to show the code tables, the order of the valid flag, the exact tMRD boundary, and the cases that the clock enable and chip select cause to be ignored. To do this, the bench compares every output against a model built from the requirements, using directed corner cases and long random command streams.

// File: rtl/mode_reg_decoder.sv
module mode_reg_decoder #(
  parameter int TMRD = 2,
  parameter int AW   = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cke,
  input  logic          cs_n,
  input  logic          ras_n,
  input  logic          cas_n,
  input  logic          we_n,
  input  logic [1:0]    ba,
  input  logic [AW-1:0] addr,
  input  logic          banks_idle,
  output logic [3:0]    burst_len,
  output logic          burst_interleave,
  output logic [2:0]    read_lat_x2,
  output logic          dll_on,
  output logic          drive_weak,
  output logic          dll_reset_pulse,
  output logic          cfg_valid,
  output logic          err
);
  localparam int GW = (TMRD > 1) ? $clog2(TMRD) : 1;

  logic          cke_q;
  logic [GW-1:0] gap;
  logic [1:0]    bl_code;
  logic          ext_seen;

  wire cmd_on  = cke & cke_q & ~cs_n & ~(ras_n & cas_n & we_n);
  wire wr      = cmd_on & ~ras_n & ~cas_n & ~we_n;
  wire busy    = (gap != '0);

  wire bl_ok   = (addr[2:0] == 3'b001) | (addr[2:0] == 3'b010) | (addr[2:0] == 3'b011);
  wire cl_ok   = (addr[6:4] == 3'b011) | (addr[6:4] == 3'b110);
  wire mrs_ok  = ~ba[1] & bl_ok & cl_ok & ~addr[7] & ~|addr[AW-1:9];
  wire emrs_ok = ~ba[1] & ~|addr[5:2] & ~|addr[AW-1:7];
  wire legal   = banks_idle & ~busy & (ba[0] ? emrs_ok : mrs_ok);
  wire take    = wr & legal;
  wire reject  = (cmd_on & busy) | (wr & ~legal);

  assign burst_len = (bl_code == 2'd0) ? 4'd0 : (4'd1 << bl_code);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cke_q            <= 1'b0;
      gap              <= '0;
      bl_code          <= 2'd0;
      burst_interleave <= 1'b0;
      read_lat_x2      <= 3'd0;
      dll_on           <= 1'b0;
      drive_weak       <= 1'b0;
      dll_reset_pulse  <= 1'b0;
      ext_seen         <= 1'b0;
      cfg_valid        <= 1'b0;
      err              <= 1'b0;
    end else begin
      cke_q           <= cke;
      dll_reset_pulse <= 1'b0;
      if (reject) err <= 1'b1;
      if (take) gap <= GW'(TMRD - 1);
      else if (busy) gap <= gap - 1'b1;
      if (take && ba[0]) begin
        dll_on     <= ~addr[0];
        drive_weak <= addr[1];
        ext_seen   <= 1'b1;
      end
      if (take && !ba[0]) begin
        bl_code          <= addr[1:0];
        burst_interleave <= addr[3];
        read_lat_x2      <= (addr[6:4] == 3'b011) ? 3'd6 : 3'd5;
        dll_reset_pulse  <= addr[8];
        if (ext_seen) cfg_valid <= 1'b1;
      end
    end
  end

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) err |=> err);

  // R9
  valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) cfg_valid |=> cfg_valid);

  // R7
  busy_bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !banks_idle |=> ($stable(burst_len) && $stable(burst_interleave) && $stable(read_lat_x2)
                     && $stable(dll_on) && $stable(drive_weak)));

  // R6
  dll_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dll_reset_pulse |-> $past(!cs_n && !ras_n && !cas_n && !we_n && !ba[0] && addr[8] && banks_idle));
endmodule

// File: tb/tb_mode_reg_decoder.sv
module tb_mode_reg_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int TMRD = 2;

  logic clk = 1'b0, rst_n = 1'b0, cke = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic [12:0] addr = '0;
  logic banks_idle = 1'b1;
  logic [3:0] burst_len;
  logic burst_interleave, dll_on, drive_weak, dll_reset_pulse, cfg_valid, err;
  logic [2:0] read_lat_x2;

  int total = 0, bad = 0;

  mode_reg_decoder #(.TMRD(TMRD), .AW(13)) dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .banks_idle(banks_idle), .burst_len(burst_len),
    .burst_interleave(burst_interleave), .read_lat_x2(read_lat_x2), .dll_on(dll_on),
    .drive_weak(drive_weak), .dll_reset_pulse(dll_reset_pulse), .cfg_valid(cfg_valid), .err(err));

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [3:0] m_bl; logic m_bt; logic [2:0] m_lat; logic m_dll, m_weak, m_pulse, m_valid, m_err, m_ext, m_ckeq;
  int m_gap;

  function automatic logic main_legal(logic [1:0] b, logic [12:0] a);
    logic blok, clok;
    blok = (a[2:0] >= 3'd1) && (a[2:0] <= 3'd3);
    clok = (a[6:4] == 3'd3) || (a[6:4] == 3'd6);
    return !b[1] && blok && clok && !a[7] && (a[12:9] == 4'd0);
  endfunction

  function automatic logic ext_legal(logic [1:0] b, logic [12:0] a);
    return !b[1] && (a[5:2] == 4'd0) && (a[12:7] == 6'd0);
  endfunction

  task automatic chk(string tag, int act, int exp, string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, burst_len, m_bl, "burst_len");
    chk(tag, burst_interleave, m_bt, "burst_interleave");
    chk(tag, read_lat_x2, m_lat, "read_lat_x2");
    chk(tag, dll_on, m_dll, "dll_on");
    chk(tag, drive_weak, m_weak, "drive_weak");
    chk(tag, dll_reset_pulse, m_pulse, "dll_reset_pulse");
    chk(tag, cfg_valid, m_valid, "cfg_valid");
    chk(tag, err, m_err, "err");
  endtask

  task automatic model_reset();
    m_bl = 0; m_bt = 0; m_lat = 0; m_dll = 0; m_weak = 0; m_pulse = 0;
    m_valid = 0; m_err = 0; m_ext = 0; m_ckeq = 0; m_gap = 0;
  endtask

  task automatic step(logic k, logic c, logic r, logic ca, logic w, logic [1:0] b,
                      logic [12:0] a, logic idle, string tag, logic do_chk = 1'b1);
    logic on, wr, ok, take;
    cke = k; cs_n = c; ras_n = r; cas_n = ca; we_n = w; ba = b; addr = a; banks_idle = idle;
    on = k && m_ckeq && !c && !(r && ca && w);
    wr = on && !r && !ca && !w;
    ok = idle && (m_gap == 0) && (b[0] ? ext_legal(b, a) : main_legal(b, a));
    take = wr && ok;
    m_ckeq = k;
    m_pulse = 0;
    if ((on && m_gap != 0) || (wr && !ok)) m_err = 1;
    if (take) m_gap = TMRD - 1; else if (m_gap > 0) m_gap--;
    if (take && b[0]) begin m_dll = !a[0]; m_weak = a[1]; m_ext = 1; end
    if (take && !b[0]) begin
      m_bl = 4'd1 << a[1:0]; m_bt = a[3];
      m_lat = (a[6:4] == 3'd3) ? 3'd6 : 3'd5;
      m_pulse = a[8];
      if (m_ext) m_valid = 1;
    end
    @(posedge clk); @(negedge clk);
    if (do_chk) check_all(tag);
  endtask

  task automatic nop(string tag); step(1, 1, 1, 1, 1, 2'b00, 13'd0, 1, tag); endtask
  task automatic wrt(logic [1:0] b, logic [12:0] a, string tag, logic idle = 1'b1);
    step(1, 0, 0, 0, 0, b, a, idle, tag);
  endtask

  task automatic do_reset(string tag);
    rst_n = 0; cke = 0; cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1; ba = 0; addr = 0; banks_idle = 1;
    repeat (2) @(negedge clk);
    model_reset();
    check_all(tag);
    rst_n = 1;
    nop(tag);
  endtask

  function automatic logic [12:0] ma(logic [2:0] bl, logic bt, logic [2:0] cl, logic a8);
    return {4'd0, a8, 1'b0, cl, bt, bl};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    do_reset("R1 reset state");

    wrt(2'b00, ma(3'b010, 0, 3'b011, 0), "R2 R9 main before ext, BL4 CL3");
    nop("R9 gap");
    wrt(2'b01, 13'b0, "R5 ext dll on full drive");
    nop("R5 gap");
    wrt(2'b00, ma(3'b011, 1, 3'b110, 0), "R3 R4 R9 BL8 interleave CL2.5");
    nop("R8 gap");
    wrt(2'b00, ma(3'b001, 0, 3'b011, 0), "R2 BL2 exactly TMRD later");
    nop("R8 gap2");
    wrt(2'b01, 13'h0043, "R5 ext dll off weak A6 ignored");
    nop("R6 gap");
    wrt(2'b00, ma(3'b010, 0, 3'b011, 1), "R6 dll reset pulse high");
    nop("R6 dll reset pulse dropped");
    step(0, 0, 0, 0, 0, 2'b00, ma(3'b011, 1, 3'b110, 0), 1, "R11 cke low ignored");
    step(1, 0, 0, 0, 0, 2'b00, ma(3'b011, 1, 3'b110, 0), 1, "R11 cke just raised ignored");
    step(1, 1, 0, 0, 0, 2'b00, ma(3'b011, 1, 3'b110, 0), 1, "R11 cs high ignored");

    do_reset("R8 reset");
    wrt(2'b01, 13'b0, "R8 ext");
    wrt(2'b00, ma(3'b010, 0, 3'b011, 0), "R8 write inside tMRD rejected");
    wrt(2'b00, ma(3'b010, 0, 3'b011, 0), "R10 err sticky, later write accepted");

    do_reset("R8b reset");
    wrt(2'b01, 13'b0, "R8b ext");
    step(1, 0, 0, 1, 1, 2'b00, 13'd5, 1, "R8 activate inside tMRD rejected");

    do_reset("R7 reset");
    wrt(2'b00, ma(3'b010, 0, 3'b011, 0), "R7 busy bank rejected", 1'b0);

    do_reset("R2 reset"); wrt(2'b00, ma(3'b000, 0, 3'b011, 0), "R2 reserved BL 000 rejected");
    do_reset("R2b reset"); wrt(2'b00, ma(3'b111, 0, 3'b011, 0), "R2 reserved BL 111 rejected");
    do_reset("R4 reset"); wrt(2'b00, ma(3'b010, 0, 3'b010, 0), "R4 reserved CL 010 rejected");
    do_reset("R6 reset"); wrt(2'b00, ma(3'b010, 0, 3'b011, 0) | 13'h0080, "R6 test mode A7 rejected");
    do_reset("R6b reset"); wrt(2'b10, ma(3'b010, 0, 3'b011, 0), "R6 BA1 set rejected");
    do_reset("R6c reset"); wrt(2'b00, ma(3'b010, 0, 3'b011, 0) | 13'h0200, "R6 A9 set rejected");
    do_reset("R5 reset"); wrt(2'b01, 13'h0004, "R5 ext A2 set rejected");
    do_reset("R5b reset"); wrt(2'b01, 13'h1000, "R5 ext A12 set rejected");

    for (int i = 0; i < 3000; i++) begin
      int kind;
      logic [12:0] a;
      logic [1:0] b;
      logic idle, k;
      if (i % 150 == 0) do_reset("R1 random reset");
      kind = $urandom % 5;
      idle = ($urandom % 8) != 0;
      k = ($urandom % 25) != 0;
      b = {($urandom % 16) == 0, 1'b0};
      if ($urandom % 4 == 0) a = 13'($urandom);
      else a = ma(3'($urandom % 4), 1'($urandom), ($urandom % 2) ? 3'b011 : 3'b110, ($urandom % 6) == 0);
      case (kind)
        0, 1: step(k, 0, 0, 0, 0, b, a, idle, "R2 R3 R4 R6 R7 R8 R10 random main");
        2: begin
          if ($urandom % 3 != 0) a = {6'd0, 1'($urandom), 4'd0, 2'($urandom)};
          step(k, 0, 0, 0, 0, {b[1], 1'b1}, a, idle, "R5 R7 R8 R9 random ext");
        end
        3: step(k, 0, 0, 1, 1, b, a, idle, "R8 R11 random other command");
        default: step(k, 1'($urandom), 1, 1, 1, b, a, idle, "R11 random idle cycle");
      endcase
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule